// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire serial link. The three wires are an active-high enable, a serial clock, and one data line whose direction changes during a transfer. The block gives an external host access to a small bank of clock registers and a scratch RAM. Both storage arrays sit outside the block and are reached through a simple internal port: the block drives a write strobe, a space select, an address and write data, and it receives read data combinationally for the address it presents.

Each transfer starts when the enable line goes high. The host then clocks in one command byte, least-significant bit first. The command selects read or write, the clock space or the RAM space, and an address. The reserved address 31 selects burst mode. After the command, the host clocks either one data byte or a run of data bytes through the block, in or out. A write-protect flag lives in the clock-space control register. That register is held inside the block, and the flag blocks writes to every other location. Driving the enable low at any point ends the transfer.

All three serial inputs pass through a synchronizer of configurable depth. The link is oversampled by the system clock.

Top module: `tw_serial_slave`

## Requirements
- R1: After system reset and while `ce` is low, `sdio_oe` is 0 and `reg_we` never pulses, whatever `sclk` and `sdio_i` do.
- R2: The first 8 rising `sclk` edges after `ce` goes high shift in a command byte, LSB first. Bit 0 = 1 means read and 0 means write. Bits 5:1 hold the address. Bit 6 = 1 selects RAM and 0 selects the clock space. A command whose bit 7 is 0 is ignored until `ce` next falls: no write, no drive.
- R3: A write sends one data byte LSB first on rising edges. Once the 8th bit arrives, `reg_we` pulses for exactly one system clock, with the byte on `reg_wdata` and the command address on `reg_addr`.
- R4: A read fetches the addressed byte on the falling `sclk` edge after the 8th command bit. On that edge the block sets `sdio_oe` and drives bit 0. Each further falling edge presents the next bit, LSB first.
- R5: Address 31 selects burst mode. The transfer starts at address 0 and moves to the next address after each byte. It wraps to 0 after address `CLK_REGS-1` in clock space or `RAM_BYTES-1` in RAM space.
- R6: Clock address `CTRL_ADDR` is the control register. Bit 7 of a byte written there becomes the write-protect flag, and such a write is always accepted. The register reads as {flag, 7'b0000000}. While the flag is 1, writes to every other clock or RAM location are dropped.
- R7: Driving `ce` low aborts the transfer. `sdio_oe` falls, a partly received data byte is not written, and the next transfer begins with a fresh command byte.
- R8: `reg_space` carries command bit 6 for both reads and writes, so clock and RAM locations with equal addresses stay distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| ce | input | 1 | Serial enable, active high |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen at the pin |
| sdio_o | output | 1 | Data driven onto the line during reads |
| sdio_oe | output | 1 | Output enable for the data line driver |
| reg_we | output | 1 | One-cycle write strobe to the register bank |
| reg_space | output | 1 | 1 = RAM space, 0 = clock space |
| reg_addr | output | 5 | Bank address |
| reg_wdata | output | 8 | Bank write data |
| reg_rdata | input | 8 | Bank read data for the presented address |

## Verification
Burst runs go one byte past the end of each space, so an address sequencer that overran or used the wrong limit would write or return the wrong location for the wrap byte. Write-protect is set, tested against both spaces, read back with all low bits written as ones, and then cleared. A design that gated the control register itself would lock forever, and one that stored bits 6:0 would read back as nonzero. Transfers are cut off in the middle of a write byte and in the middle of a read. A design that committed partial bytes would corrupt the bank, and one that kept its bit counter would misparse the next command. A command with bit 7 clear is followed by data, to catch a decoder that acts on invalid commands.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [1:0] {
      ST_CMD   = 2'd0,
      ST_WDATA = 2'd1,
      ST_RDATA = 2'd2,
      ST_SKIP  = 2'd3
   } tw_state_e;

   typedef struct packed {
      logic       valid;
      logic       ram;
      logic [4:0] addr;
      logic       rd;
   } tw_cmd_t;

   function automatic tw_cmd_t tw_decode(input logic [7:0] b);
      tw_cmd_t c;
      c.valid = b[7];
      c.ram   = b[6];
      c.addr  = b[5:1];
      c.rd    = b[0];
      return c;
   endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] ff [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) ff[i] <= '0;
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tw_addr_seq.sv
module tw_addr_seq #(
   parameter int ADDR_W    = 5,
   parameter int CLK_REGS  = 8,
   parameter int RAM_BYTES = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_ram,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr,
   output logic              burst,
   output logic              ram
);

   localparam logic [ADDR_W-1:0] BURST_CODE = '1;
   localparam logic [ADDR_W-1:0] CLK_LAST   = ADDR_W'(CLK_REGS - 1);
   localparam logic [ADDR_W-1:0] RAM_LAST   = ADDR_W'(RAM_BYTES - 1);

   logic [ADDR_W-1:0] last;
   assign last = ram ? RAM_LAST : CLK_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         burst <= 1'b0;
         ram   <= 1'b0;
      end else if (load) begin
         addr  <= (ld_addr == BURST_CODE) ? '0 : ld_addr;
         burst <= (ld_addr == BURST_CODE);
         ram   <= ld_ram;
      end else if (advance && burst) begin
         addr  <= (addr == last) ? '0 : addr + 1'b1;
      end
   end

   // R5
   burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst |-> (addr <= last));

   // R5
   burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && burst && !load && addr == last) |=> (addr == '0));

endmodule

// File: rtl/tw_serial_slave.sv
module tw_serial_slave #(
   parameter int CLK_REGS    = 8,
   parameter int RAM_BYTES   = 24,
   parameter int CTRL_ADDR   = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       sclk,
   input  logic       sdio_i,
   output logic       sdio_o,
   output logic       sdio_oe,
   output logic       reg_we,
   output logic       reg_space,
   output logic [4:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata
);
   import tw_pkg::*;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 8;
   localparam int CNT_W  = $clog2(DATA_W);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);

   generate
      if (CLK_REGS < 1 || CLK_REGS >= (1 << ADDR_W)) begin : g_bad_clk
         $error("CLK_REGS out of range");
      end
      if (RAM_BYTES < 1 || RAM_BYTES >= (1 << ADDR_W)) begin : g_bad_ram
         $error("RAM_BYTES out of range");
      end
      if (CTRL_ADDR < 0 || CTRL_ADDR >= CLK_REGS) begin : g_bad_ctrl
         $error("CTRL_ADDR must lie inside the clock space");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       ce_s, sclk_s, din_s, sclk_q;
   logic       rise, fall;

   tw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce, sclk, sdio_i}),
      .q     (sync_q)
   );
   assign {ce_s, sclk_s, din_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end
   assign rise = ce_s &&  sclk_s && !sclk_q;
   assign fall = ce_s && !sclk_s &&  sclk_q;

   tw_state_e        st;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       rx_sh, tx_sh, rx_next, rd_byte;
   tw_cmd_t          cmd_q, cmd_next;
   logic             oe_q, wp_q, we_q;
   logic [7:0]       wdata_q;
   logic [4:0]       wr_addr_q;
   logic             byte_done, cmd_done, advance;
   logic [4:0]       seq_addr;
   logic             seq_burst, seq_ram;

   assign rx_next   = {din_s, rx_sh[7:1]};
   assign cmd_next  = tw_decode(rx_next);
   assign byte_done = rise && (bit_cnt == LAST_BIT);
   assign cmd_done  = byte_done && (st == ST_CMD);
   assign advance   = byte_done && (st == ST_WDATA || st == ST_RDATA);

   tw_addr_seq #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_done && ce_s),
      .ld_addr (cmd_next.addr),
      .ld_ram  (cmd_next.ram),
      .advance (advance && ce_s),
      .addr    (seq_addr),
      .burst   (seq_burst),
      .ram     (seq_ram)
   );

   assign rd_byte = (!seq_ram && seq_addr == CTRL_A) ? {wp_q, 7'b0000000} : reg_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_CMD;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         cmd_q     <= '0;
         oe_q      <= 1'b0;
         wp_q      <= 1'b0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         wr_addr_q <= '0;
      end else begin
         we_q <= 1'b0;
         if (!ce_s) begin
            st      <= ST_CMD;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else begin
            unique case (st)
               ST_CMD: if (rise) begin
                  rx_sh   <= rx_next;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_done) begin
                     cmd_q <= cmd_next;
                     if (!cmd_next.valid)  st <= ST_SKIP;
                     else if (cmd_next.rd) st <= ST_RDATA;
                     else                  st <= ST_WDATA;
                  end
               end
               ST_WDATA: if (rise) begin
                  rx_sh   <= rx_next;
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_done) begin
                     if (!seq_ram && seq_addr == CTRL_A) begin
                        wp_q <= rx_next[7];
                     end else if (!wp_q) begin
                        we_q      <= 1'b1;
                        wdata_q   <= rx_next;
                        wr_addr_q <= seq_addr;
                     end
                     if (!seq_burst) st <= ST_SKIP;
                  end
               end
               ST_RDATA: begin
                  if (fall) begin
                     if (bit_cnt == '0) begin
                        tx_sh <= rd_byte;
                        oe_q  <= 1'b1;
                     end else begin
                        tx_sh <= {1'b0, tx_sh[7:1]};
                     end
                  end
                  if (rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                     if (byte_done && !seq_burst) begin
                        st   <= ST_SKIP;
                        oe_q <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sdio_o    = tx_sh[0];
   assign sdio_oe   = oe_q;
   assign reg_we    = we_q;
   assign reg_wdata = wdata_q;
   assign reg_addr  = we_q ? wr_addr_q : seq_addr;
   assign reg_space = seq_ram;

   // R7
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !sdio_oe);

   // R4
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> (cmd_q.rd && cmd_q.valid));

   // R6
   wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !wp_q);

   // R3
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP && !cmd_q.valid) |-> (!reg_we && !sdio_oe));

endmodule

// File: tb/sim_tw_serial_slave.sv
module sim_tw_serial_slave;

   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, sclk = 1'b0, sdio_i = 1'b0;
   logic sdio_o, sdio_oe, reg_we, reg_space;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   always #10 clk = ~clk;

   tw_serial_slave u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdio_i(sdio_i),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_we(reg_we), .reg_space(reg_space),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // register bank seen by the block
   logic [7:0] clk_bank [8];
   logic [7:0] ram_bank [24];
   // expected contents
   logic [7:0] exp_clk [8];
   logic [7:0] exp_ram [24];
   logic       exp_wp;
   int n_chk = 0, n_err = 0, we_count = 0, ce_low_cnt = 0;
   bit done = 0;

   always_comb begin
      if (reg_space) reg_rdata = (reg_addr < 24) ? ram_bank[reg_addr] : 8'h00;
      else           reg_rdata = (reg_addr < 8)  ? clk_bank[reg_addr] : 8'h00;
   end

   always @(posedge clk) begin
      if (reg_we) begin
         we_count <= we_count + 1;
         if (reg_space && reg_addr < 24) ram_bank[reg_addr] <= reg_wdata;
         if (!reg_space && reg_addr < 8) clk_bank[reg_addr] <= reg_wdata;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock monitor: line released while enable has been low (R1, R7)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (ce) ce_low_cnt <= 0;
         else    ce_low_cnt <= ce_low_cnt + 1;
         if (ce_low_cnt >= 5) chk("R7 oe idle", int'(sdio_oe), 0);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic wait_h(); repeat (H) @(negedge clk); endtask

   task automatic send_bit(input logic b);
      @(negedge clk); sdio_i = b;
      wait_h(); sclk = 1'b1;
      wait_h(); sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
   endtask

   task automatic recv_byte(input string req, output logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         wait_h();
         chk({req, " oe"}, int'(sdio_oe), 1);
         v[i] = sdio_o;
         sclk = 1'b1;
         wait_h(); sclk = 1'b0;
      end
   endtask

   task automatic begin_xfer(); @(negedge clk); ce = 1'b1; wait_h(); endtask
   task automatic end_xfer(); wait_h(); ce = 1'b0; wait_h(); wait_h(); endtask

   function automatic logic [7:0] cmd(input logic rd, input logic ram, input int a);
      return {1'b1, ram, 5'(a), rd};
   endfunction

   function automatic void model_write(input logic ram, input int a, input logic [7:0] d);
      if (!ram && a == 7) exp_wp = d[7];
      else if (!exp_wp) begin
         if (ram) exp_ram[a] = d; else exp_clk[a] = d;
      end
   endfunction

   function automatic logic [7:0] model_read(input logic ram, input int a);
      if (!ram && a == 7) return {exp_wp, 7'b0};
      return ram ? exp_ram[a] : exp_clk[a];
   endfunction

   task automatic cmp_banks(input string req);
      for (int i = 0; i < 8; i++) if (i != 7) chk({req, " clk bank"}, int'(clk_bank[i]), int'(exp_clk[i]));
      for (int i = 0; i < 24; i++) chk({req, " ram bank"}, int'(ram_bank[i]), int'(exp_ram[i]));
   endtask

   task automatic wr1(input logic ram, input int a, input logic [7:0] d);
      begin_xfer(); send_byte(cmd(1'b0, ram, a)); send_byte(d); end_xfer();
      model_write(ram, a, d);
   endtask

   task automatic rd1(input string req, input logic ram, input int a);
      logic [7:0] v;
      begin_xfer(); send_byte(cmd(1'b1, ram, a)); recv_byte(req, v); end_xfer();
      chk(req, int'(v), int'(model_read(ram, a)));
   endtask

   initial begin
      int wc;
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin clk_bank[i] = 8'(i * 17 + 3); exp_clk[i] = 8'(i * 17 + 3); end
      for (int i = 0; i < 24; i++) begin ram_bank[i] = 8'(i * 5 + 100); exp_ram[i] = 8'(i * 5 + 100); end
      exp_wp = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: idle after reset, sclk toggling with ce low has no effect
      chk("R1 oe after reset", int'(sdio_oe), 0);
      for (int i = 0; i < 16; i++) send_bit(1'b1);
      chk("R1 oe with ce low", int'(sdio_oe), 0);
      chk("R1 no writes", we_count, 0);

      // R3 / R8: single writes to both spaces at equal address
      wr1(1'b0, 2, 8'h5A);
      wr1(1'b1, 2, 8'hC3);
      cmp_banks("R3");
      chk("R8 two distinct writes", we_count, 2);
      wr1(1'b1, 23, 8'h81);
      cmp_banks("R8");

      // R4: single reads
      rd1("R4 read clk 2", 1'b0, 2);
      rd1("R4 read ram 2", 1'b1, 2);
      rd1("R4 read ram 23", 1'b1, 23);
      rd1("R4 read clk 0", 1'b0, 0);

      // R2: invalid command (bit 7 clear) followed by data
      wc = we_count;
      begin_xfer(); send_byte(8'h04); send_byte(8'hFF);
      chk("R2 invalid no drive", int'(sdio_oe), 0);
      end_xfer();
      chk("R2 invalid no write", we_count, wc);
      cmp_banks("R2");
      begin_xfer(); send_byte(8'h05);
      for (int i = 0; i < 8; i++) begin wait_h(); chk("R2 invalid read no drive", int'(sdio_oe), 0); sclk = 1'b1; wait_h(); sclk = 1'b0; end
      end_xfer();

      // R5: clock burst write of 9 bytes (wraps onto address 0)
      begin_xfer(); send_byte(cmd(1'b0, 1'b0, 31));
      for (int i = 0; i < 9; i++) begin
         logic [7:0] d;
         d = (i % 8 == 7) ? 8'h00 : 8'(8'h20 + i);
         send_byte(d); model_write(1'b0, i % 8, d);
      end
      end_xfer();
      cmp_banks("R5 clk burst");

      // R5: RAM burst write of 25 bytes, then read back 25 with wrap
      begin_xfer(); send_byte(cmd(1'b0, 1'b1, 31));
      for (int i = 0; i < 25; i++) begin
         logic [7:0] d;
         d = 8'(8'hA0 ^ (i * 7));
         send_byte(d); model_write(1'b1, i % 24, d);
      end
      end_xfer();
      cmp_banks("R5 ram burst");
      begin_xfer(); send_byte(cmd(1'b1, 1'b1, 31));
      for (int i = 0; i < 25; i++) begin
         recv_byte("R5 ram burst read", v);
         chk("R5 ram burst read", int'(v), int'(model_read(1'b1, i % 24)));
      end
      end_xfer();
      begin_xfer(); send_byte(cmd(1'b1, 1'b0, 31));
      for (int i = 0; i < 9; i++) begin
         recv_byte("R5 clk burst read", v);
         chk("R5 clk burst read", int'(v), int'(model_read(1'b0, i % 8)));
      end
      end_xfer();

      // R6: write protect
      wr1(1'b0, 7, 8'hFF);
      rd1("R6 ctrl reads flag only", 1'b0, 7);
      wc = we_count;
      wr1(1'b0, 3, 8'h11);
      wr1(1'b1, 1, 8'h22);
      chk("R6 protected no strobe", we_count, wc);
      cmp_banks("R6 protected");
      rd1("R6 protected read clk 3", 1'b0, 3);
      wr1(1'b0, 7, 8'h7F);
      rd1("R6 ctrl cleared", 1'b0, 7);
      wr1(1'b0, 3, 8'h33);
      cmp_banks("R6 unprotected");

      // R7: abort in the middle of a write byte
      wc = we_count;
      begin_xfer(); send_byte(cmd(1'b0, 1'b0, 4));
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      end_xfer();
      chk("R7 partial byte not written", we_count, wc);
      cmp_banks("R7 abort write");
      // R7: abort in the middle of a read
      begin_xfer(); send_byte(cmd(1'b1, 1'b1, 5));
      for (int i = 0; i < 3; i++) begin wait_h(); sclk = 1'b1; wait_h(); sclk = 1'b0; end
      @(negedge clk); ce = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 oe released", int'(sdio_oe), 0);
      wait_h();
      rd1("R7 fresh read after abort", 1'b1, 5);
      wr1(1'b0, 4, 8'h44);
      cmp_banks("R7 fresh write after abort");

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule